// File: doc/BRIEF.md
# Fowler Coadd Frame Accumulator

This block turns a stream of detector pixel reads into one finished image per exposure. Every incoming read carries a pixel index and a role bit: it is either a pedestal read, taken just after the detector reset, or a signal read, taken at the end of the integration. In correlated (double) mode the block adds signal reads and subtracts pedestal reads, pixel by pixel. In single mode it keeps only the signal reads and drops pedestal reads. Several non-destructive reads of each kind make up one coadd, and the per-coadd results of consecutive coadds are summed into a single signed result memory.

An exposure begins with a one-cycle `start` pulse. The pulse captures the mode, the reads-per-group count and the coadd count, and it zeroes the image. The block then counts accepted frames. A frame ends on the accepted read whose index is the last pixel. When the final frame of the final coadd has gone in, `busy` falls and `done` rises. Reads can arrive on every clock with no gap. An `abort` pulse ends the exposure at once. Once `done` is high, the host reads the image one pixel at a time through `rd_idx`/`rd_data`.

Top module: `fowler_coadd_acc`

## Requirements
- R1: In double mode (`cfg_double`=1), each pixel's result equals, summed over all coadds, the total of its signal reads minus the total of its pedestal reads. Role encoding: `pix_is_sample`=1 marks a signal read and 0 marks a pedestal read.
- R2: In single mode (`cfg_double`=0), a pedestal-tagged read changes no pixel and does not count toward frame completion.
- R3: One coadd is `cfg_ndr` accepted frames in single mode and 2×`cfg_ndr` in double mode. A frame ends on the accepted read with index NPIX-1. `cfg_ndr` is used in the range 1 to 128: 0 is taken as 1 and values above 128 as 128.
- R4: `cfg_coadd` coadds, in the range 1 to 1000, make one exposure: 0 is taken as 1 and values above 1000 as 1000. In the cycle after the last read of the last coadd is accepted, `busy` is 0 and `done` is 1. `done` is never 1 while `busy` is 1.
- R5: Reads that arrive on consecutive clocks, including across frame and coadd boundaries, are all accumulated with no loss.
- R6: A `start` pulse zeroes every pixel. In the next cycle `busy` is 1 and `done` is 0.
- R7: A cycle with `pix_valid`=0 changes no pixel and no frame count, whatever the other pixel inputs hold.
- R8: An `abort` pulse zeroes every pixel. In the next cycle `busy` is 0 and `done` is 0.
- R9: Results are ACC_W-bit (41) two's-complement values, so negative differences read back correctly. `rd_data` shows pixel `rd_idx` one clock after `rd_idx` is applied.
- R10: Reads presented while `busy` is 0 change no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exposure: captures the settings and zeroes the image |
| abort | input | 1 | End the exposure now and zero the image |
| cfg_double | input | 1 | 1 = double (pedestal-subtracting) mode, 0 = single mode |
| cfg_ndr | input | NDR_W (8) | Non-destructive reads per pedestal or signal group |
| cfg_coadd | input | CO_W (10) | Coadds per exposure |
| pix_valid | input | 1 | A read is present this cycle |
| pix_is_sample | input | 1 | Role of the read: 1 = signal, 0 = pedestal |
| pix_idx | input | IDX_W (4) | Pixel index of the read |
| pix_data | input | PIX_W (16) | Unsigned read value |
| rd_idx | input | IDX_W (4) | Pixel to read back |
| rd_data | output | ACC_W (41) | Signed result of pixel `rd_idx`, one cycle later |
| busy | output | 1 | Exposure in progress |
| done | output | 1 | Last exposure finished; held until the next start or abort |

## Verification
The hardest case to reach from the ports is a group count at its upper limit. There, a frame counter and a coadd counter must both roll over at the same accepted read, and that read must land while reads are still streaming with no idle cycle between them. The stimulus reaches it with a table entry of 128 reads in double mode over two coadds, fed every clock with no gaps. A max-value pedestal entry drives the result negative. Pedestal frames are mixed into single-mode runs, invalid cycles carrying a last-pixel index are placed inside frames, and a frame is sent after an abort to show it is dropped.

// File: rtl/fca_pkg.sv
package fca_pkg;
  typedef enum logic {
    ROLE_PED  = 1'b0,
    ROLE_SAMP = 1'b1
  } role_e;

  function automatic logic [7:0] clamp_ndr(input logic [7:0] v);
    if (v == 8'd0) return 8'd1;
    if (v > 8'd128) return 8'd128;
    return v;
  endfunction

  function automatic logic [9:0] clamp_coadd(input logic [9:0] v);
    if (v == 10'd0) return 10'd1;
    if (v > 10'd1000) return 10'd1000;
    return v;
  endfunction
endpackage

// File: rtl/fca_seq.sv
module fca_seq #(
  parameter int NDR_W = 8,
  parameter int CO_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             cfg_double,
  input  logic [NDR_W-1:0] cfg_ndr,
  input  logic [CO_W-1:0]  cfg_coadd,
  input  logic             fire,
  input  logic             fire_last,
  output logic             busy,
  output logic             done,
  output logic             dbl
);
  localparam int FR_W = NDR_W + 1;

  logic             busy_q, busy_d, done_q, done_d, dbl_q, dbl_d;
  logic [NDR_W-1:0] ndr_q, ndr_d;
  logic [CO_W-1:0]  lim_q, lim_d, co_q, co_d;
  logic [FR_W-1:0]  fr_q, fr_d, fr_per;

  assign fr_per = dbl_q ? {ndr_q, 1'b0} : {1'b0, ndr_q};

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    dbl_d  = dbl_q;
    ndr_d  = ndr_q;
    lim_d  = lim_q;
    co_d   = co_q;
    fr_d   = fr_q;
    if (abort) begin
      busy_d = 1'b0;
      done_d = 1'b0;
      co_d   = '0;
      fr_d   = '0;
    end else if (start) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      dbl_d  = cfg_double;
      ndr_d  = fca_pkg::clamp_ndr(cfg_ndr);
      lim_d  = fca_pkg::clamp_coadd(cfg_coadd);
      co_d   = '0;
      fr_d   = '0;
    end else if (fire && fire_last) begin
      if (fr_q == fr_per - 1'b1) begin
        fr_d = '0;
        if (co_q == lim_q - 1'b1) begin
          co_d   = '0;
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          co_d = co_q + 1'b1;
        end
      end else begin
        fr_d = fr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dbl_q  <= 1'b0;
      ndr_q  <= 8'd1;
      lim_q  <= 10'd1;
      co_q   <= '0;
      fr_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      dbl_q  <= dbl_d;
      ndr_q  <= ndr_d;
      lim_q  <= lim_d;
      co_q   <= co_d;
      fr_q   <= fr_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign dbl  = dbl_q;
endmodule

// File: rtl/fca_bank.sv
module fca_bank #(
  parameter int NPIX  = 16,
  parameter int PIX_W = 16,
  parameter int ACC_W = 41,
  parameter int IDX_W = $clog2(NPIX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic                    wr_neg,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [PIX_W-1:0]        wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic signed [ACC_W-1:0] rd_data
);
  logic signed [ACC_W-1:0] mem [NPIX];
  logic signed [ACC_W-1:0] delta;
  logic signed [ACC_W-1:0] rd_q;

  always_comb begin
    delta = $signed({{(ACC_W-PIX_W){1'b0}}, wr_data});
    if (wr_neg) delta = -delta;
  end

  for (genvar g = 0; g < NPIX; g++) begin : g_cell
    logic signed [ACC_W-1:0] cell_d;
    always_comb begin
      cell_d = mem[g];
      if (clr) cell_d = '0;
      else if (wr_en && (wr_idx == IDX_W'(g))) cell_d = mem[g] + delta;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else        mem[g] <= cell_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[rd_idx];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/fowler_coadd_acc.sv
module fowler_coadd_acc #(
  parameter int NPIX  = 16,
  parameter int PIX_W = 16,
  parameter int ACC_W = 41,
  parameter int NDR_W = 8,
  parameter int CO_W  = 10,
  parameter int IDX_W = $clog2(NPIX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    abort,
  input  logic                    cfg_double,
  input  logic [NDR_W-1:0]        cfg_ndr,
  input  logic [CO_W-1:0]         cfg_coadd,
  input  logic                    pix_valid,
  input  logic                    pix_is_sample,
  input  logic [IDX_W-1:0]        pix_idx,
  input  logic [PIX_W-1:0]        pix_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic signed [ACC_W-1:0] rd_data,
  output logic                    busy,
  output logic                    done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  logic dbl, fire, fire_last;

  assign fire = pix_valid && busy && !start && !abort
                && (dbl || (pix_is_sample == fca_pkg::ROLE_SAMP));
  assign fire_last = (pix_idx == LAST_IDX);

  fca_seq #(.NDR_W(NDR_W), .CO_W(CO_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_double(cfg_double), .cfg_ndr(cfg_ndr), .cfg_coadd(cfg_coadd),
    .fire(fire), .fire_last(fire_last),
    .busy(busy), .done(done), .dbl(dbl)
  );

  fca_bank #(.NPIX(NPIX), .PIX_W(PIX_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(start || abort),
    .wr_en(fire), .wr_neg(pix_is_sample == fca_pkg::ROLE_PED),
    .wr_idx(pix_idx), .wr_data(pix_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );
endmodule

// File: rtl/fca_chk.sv
module fca_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic abort,
  input logic busy,
  input logic done
);
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done));
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (busy && !done));
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

bind fowler_coadd_acc fca_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
  .busy(busy), .done(done)
);

// File: tb/fowler_coadd_acc_tb.sv
module fowler_coadd_acc_tb;
  localparam int NPIX = 16;

  logic clk, rst_n, start, abort, cfg_double, pix_valid, pix_is_sample;
  logic [7:0] cfg_ndr;
  logic [9:0] cfg_coadd;
  logic [3:0] pix_idx, rd_idx;
  logic [15:0] pix_data;
  logic signed [40:0] rd_data;
  logic busy, done;
  int n_run, n_fail;

  fowler_coadd_acc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_double(cfg_double), .cfg_ndr(cfg_ndr), .cfg_coadd(cfg_coadd),
    .pix_valid(pix_valid), .pix_is_sample(pix_is_sample), .pix_idx(pix_idx),
    .pix_data(pix_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam int NV = 4;
  localparam int T_DBL [NV] = '{1, 0, 1, 1};
  localparam int T_NDR [NV] = '{2, 3, 1, 128};
  localparam int T_CO  [NV] = '{3, 2, 1, 2};
  localparam int T_PB  [NV] = '{100, 700, 65535, 10};
  localparam int T_SB  [NV] = '{500, 40, 0, 65535};

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint pval(input int base, input int i);
    return longint'((base ^ i) & 16'hFFFF);
  endfunction

  task automatic feed_frame(input bit smp, input int base, input int gap_at);
    for (int i = 0; i < NPIX; i++) begin
      if (i == gap_at) begin
        @(negedge clk);
        pix_valid = 1'b0; pix_is_sample = 1'b1;
        pix_idx = 4'(NPIX - 1); pix_data = 16'hFFFF;
      end
      @(negedge clk);
      pix_valid = 1'b1; pix_is_sample = smp;
      pix_idx = 4'(i); pix_data = 16'(pval(base, i));
    end
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    pix_valid = 1'b0; pix_data = '0; pix_idx = '0;
  endtask

  task automatic pulse_start(input bit dbl, input int ndr, input int co);
    @(negedge clk);
    start = 1'b1; cfg_double = dbl; cfg_ndr = 8'(ndr); cfg_coadd = 10'(co);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic read_pix(input int i, output longint v);
    @(negedge clk);
    rd_idx = 4'(i);
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    longint v, e;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; abort = 1'b0; cfg_double = 1'b0;
    cfg_ndr = 8'd1; cfg_coadd = 10'd1; pix_valid = 1'b0; pix_is_sample = 1'b0;
    pix_idx = '0; pix_data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset busy", busy, 0);
    chk("R6 reset done", done, 0);
    chk("R9 reset rd_data", rd_data, 0);

    // Table walk: R1 R2 R3 R4 R5 R7 R9
    for (int t = 0; t < NV; t++) begin
      pulse_start(T_DBL[t] != 0, T_NDR[t], T_CO[t]);
      chk("R6 busy after start", busy, 1);
      for (int c = 0; c < T_CO[t]; c++) begin
        if (T_DBL[t] != 0) begin
          for (int k = 0; k < T_NDR[t]; k++)
            feed_frame(1'b0, T_PB[t], (c == 0 && k == 0) ? 5 : -1);
          for (int k = 0; k < T_NDR[t]; k++)
            feed_frame(1'b1, T_SB[t], -1);
        end else begin
          for (int k = 0; k < T_NDR[t]; k++) begin
            if (k == 0) feed_frame(1'b0, T_PB[t], -1); // R2 ignored pedestal frame
            feed_frame(1'b1, T_SB[t], (c == 0 && k == 0) ? 9 : -1);
          end
        end
      end
      idle_inputs();
      chk("R4 done after last coadd", done, 1);
      chk("R4 busy low after last coadd", busy, 0);
      for (int i = 0; i < NPIX; i++) begin
        e = longint'(T_CO[t]) * longint'(T_NDR[t]) *
            (pval(T_SB[t], i) - ((T_DBL[t] != 0) ? pval(T_PB[t], i) : 0));
        read_pix(i, v);
        chk((T_DBL[t] != 0) ? "R1 R5 R9 pixel" : "R2 R3 pixel", v, e);
      end
    end

    // R10: frame after done is ignored; pixel 3 keeps entry-3 value
    e = 2 * 128 * (pval(65535, 3) - pval(10, 3));
    feed_frame(1'b1, 1234, -1);
    idle_inputs();
    read_pix(3, v);
    chk("R10 idle read ignored", v, e);
    chk("R10 done held", done, 1);

    // R6: start zeroes image and clears done
    pulse_start(1'b1, 1, 1);
    chk("R6 done cleared", done, 0);
    read_pix(3, v);
    chk("R6 image zeroed", v, 0);

    // R8: abort mid exposure
    feed_frame(1'b0, 300, -1);
    @(negedge clk);
    pix_valid = 1'b0; abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R8 busy after abort", busy, 0);
    chk("R8 done after abort", done, 0);
    read_pix(3, v);
    chk("R8 image zeroed", v, 0);
    feed_frame(1'b1, 77, -1);
    idle_inputs();
    read_pix(3, v);
    chk("R10 read after abort ignored", v, 0);

    // R3 R4: zero counts clamp to one
    pulse_start(1'b0, 0, 0);
    feed_frame(1'b1, 9, -1);
    idle_inputs();
    chk("R3 R4 zero counts clamp done", done, 1);
    read_pix(0, v);
    chk("R3 clamp pixel", v, pval(9, 0));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule